// File: doc/BRIEF.md
# Run-Time Configurable Sinc Decimator

This block turns a single-channel one-bit pulse-density stream into 24-bit signed PCM samples. It is a cascaded integrator-comb filter. Both its order (1 to 5) and its power-of-two decimation ratio (8 to 256) are taken at run time from a configuration field, so one instance can serve several sample rates and noise-shaping needs. Each accepted input bit is marked by a one-cycle bit enable. The core clock normally gives each bit 16 cycles, but the block only needs one.

Every input bit is mapped to +1 for a one or -1 for a zero and passed through the integrator chain. After every R-th bit, the selected number of comb stages differentiate the last integrator. The result is rounded and shifted by order x log2(R) - 23 (left when that is negative) so that full scale lands on 24 bits, then saturated. Changing the configuration, or dropping the run enable, restarts the filter from zero state. While the filter settles, its first N decimated results are withheld.

Top module: `sinc_decim`

## Requirements
- R1: After reset, pcm_valid and pcm_out are 0, the decimation is disabled (ratio code 0), and the order is 3.
- R2: The ratio code sits in mode_word[27:24]. Codes 1..6 select R = 8, 16, 32, 64, 128, 256. Code 0 and codes 7..15 disable the filter: no pcm_valid is produced and pcm_out keeps its value.
- R3: The order sits in mode_word[23:20]. Values 1..5 select the order N. Any other value is ignored: the previous order is kept and the filter is not restarted.
- R4: A one bit counts as +1 and a zero bit as -1. In steady state an all-ones stream yields 8388607 (saturated) and an all-zeros stream yields -8388608, for every order and ratio.
- R5: Output scaling is independent of order and ratio. A repeating 4-bit stream with one one yields -4194304, with three ones yields +4194304, and with two ones alternating yields 0.
- R6: pcm_valid is a one-cycle pulse after every R accepted bits. It is high in the cycle after the edge that accepts the R-th bit, and pcm_out changes only together with it.
- R7: A change of the effective order or the ratio code, or a low run_en, clears all filter state. After a restart, the first valid sample follows the (N+1)-th group of R bits, which means (N+1)*R accepted bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Channel run enable; low clears the filter |
| bit_en | input | 1 | One-cycle strobe marking an accepted PDM bit |
| pdm_bit | input | 1 | PDM data bit |
| mode_word | input | 8 ([27:20]) | Configuration field: ratio code [27:24], order [23:20] |
| pcm_out | output | 24 | Signed decimated sample |
| pcm_valid | output | 1 | One-cycle strobe for a new sample |

## Verification
A sample is registered at the same edge that accepts the R-th bit, so pcm_valid and its value show one cycle after that edge. The bench drives each bit on a falling edge and reads the outputs on the next falling edge, which covers exactly that one cycle. It then checks the following falling edge for the pulse falling back. A configuration change takes one registered cycle to apply, and the bench leaves idle cycles after each change before feeding bits. The bench counts accepted bits and compares the index of the first valid sample with (N+1)*R-1, which places the settling boundary to the exact bit.

// File: rtl/sinc_decim.sv
module sinc_decim #(
  parameter int OUT_W    = 24,
  parameter int ORD_MAX  = 5,
  parameter int LOG_MAX  = 8,
  parameter int CODE_MAX = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_en,
  input  logic              bit_en,
  input  logic              pdm_bit,
  input  logic [27:20]      mode_word,
  output logic [OUT_W-1:0]  pcm_out,
  output logic              pcm_valid
);
  localparam int ACC_W = 2 + ORD_MAX * LOG_MAX;
  localparam logic signed [ACC_W-1:0] PMAX = ACC_W'((64'sd1 <<< (OUT_W-1)) - 64'sd1);
  localparam logic signed [ACC_W-1:0] PMIN = -PMAX - ACC_W'(1);

  logic [3:0] ord_in, code_in, ord_nx, ord_q, code_q, lg, settle;
  logic       cfg_chg, code_ok, run, last_bit;
  logic [LOG_MAX-1:0] cnt, lim;
  logic [7:0] nl, sh;
  logic signed [ACC_W-1:0] integ    [ORD_MAX];
  logic signed [ACC_W-1:0] integ_nx [ORD_MAX];
  logic signed [ACC_W-1:0] dly      [ORD_MAX];
  logic signed [ACC_W-1:0] cmb      [ORD_MAX+1];
  logic signed [ACC_W-1:0] rnd, scaled;
  logic signed [OUT_W-1:0] sat_v;
  logic [2:0] osel;

  assign ord_in  = mode_word[23:20];
  assign code_in = mode_word[27:24];
  assign ord_nx  = (ord_in >= 4'd1 && ord_in <= 4'(ORD_MAX)) ? ord_in : ord_q;
  assign cfg_chg = (ord_nx != ord_q) || (code_in != code_q);
  assign code_ok = code_q >= 4'd1 && code_q <= 4'(CODE_MAX);
  assign run     = run_en && code_ok && !cfg_chg;
  assign lg      = code_ok ? code_q + 4'd2 : 4'd3;
  assign lim     = LOG_MAX'({LOG_MAX{1'b1}} >> (LOG_MAX - int'(lg)));
  assign last_bit = (cnt == lim);
  assign osel    = 3'(ord_q - 4'd1);
  assign nl      = {4'd0, ord_q} * {4'd0, lg};
  assign sh      = nl - 8'd23;

  always_comb begin
    integ_nx[0] = integ[0] + (pdm_bit ? ACC_W'(1) : {ACC_W{1'b1}});
    for (int k = 1; k < ORD_MAX; k++) integ_nx[k] = integ[k] + integ_nx[k-1];
    cmb[0] = integ_nx[osel];
    for (int j = 0; j < ORD_MAX; j++)
      cmb[j+1] = (4'(j) < ord_q) ? cmb[j] - dly[j] : cmb[j];
  end

  always_comb begin
    rnd = '0;
    if (nl >= 8'd23) begin
      if (sh != 8'd0) rnd = $signed(ACC_W'(1) << (sh - 8'd1));
      scaled = (cmb[ORD_MAX] + rnd) >>> sh;
    end else begin
      scaled = cmb[ORD_MAX] <<< (8'd23 - nl);
    end
    if (scaled > PMAX)      sat_v = PMAX[OUT_W-1:0];
    else if (scaled < PMIN) sat_v = PMIN[OUT_W-1:0];
    else                    sat_v = scaled[OUT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ord_q     <= 4'd3;
      code_q    <= 4'd0;
      cnt       <= '0;
      settle    <= '0;
      pcm_valid <= 1'b0;
      pcm_out   <= '0;
      for (int k = 0; k < ORD_MAX; k++) begin
        integ[k] <= '0;
        dly[k]   <= '0;
      end
    end else begin
      ord_q     <= ord_nx;
      code_q    <= code_in;
      pcm_valid <= 1'b0;
      if (!run) begin
        cnt    <= '0;
        settle <= '0;
        for (int k = 0; k < ORD_MAX; k++) begin
          integ[k] <= '0;
          dly[k]   <= '0;
        end
      end else if (bit_en) begin
        for (int k = 0; k < ORD_MAX; k++) integ[k] <= integ_nx[k];
        if (last_bit) begin
          cnt <= '0;
          for (int k = 0; k < ORD_MAX; k++) dly[k] <= cmb[k];
          if (settle == ord_q) begin
            pcm_valid <= 1'b1;
            pcm_out   <= sat_v;
          end else begin
            settle <= settle + 4'd1;
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    pcm_valid |=> !pcm_valid);
  a_r6_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    !pcm_valid |-> $stable(pcm_out));
  a_r7_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> !pcm_valid);
  a_r2_no_output_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_word[27:24] == 4'd0 || mode_word[27:24] > 4'(CODE_MAX)) |=> !pcm_valid);
endmodule

// File: tb/sinc_decim_tb.sv
module sinc_decim_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run_en = 1'b0;
  logic bit_en = 1'b0;
  logic pdm_bit = 1'b0;
  logic [7:0] mode = 8'h00;
  logic [23:0] pcm_out;
  logic pcm_valid;
  int checks = 0, errors = 0;
  int fv, nv, nbad, wbad_tot = 0;
  logic [23:0] held;
  bit done = 0;

  always #4 clk = ~clk;

  sinc_decim u_dut (.clk(clk), .rst_n(rst_n), .run_en(run_en), .bit_en(bit_en),
    .pdm_bit(pdm_bit), .mode_word(mode), .pcm_out(pcm_out), .pcm_valid(pcm_valid));

  // ord, ratio code, pattern (bit b = pat[b%4]), expected steady sample
  localparam int VEC [9][4] = '{
    '{1, 1, 15,  8388607},
    '{3, 1,  0, -8388608},
    '{2, 2,  1, -4194304},
    '{4, 3,  7,  4194304},
    '{5, 4,  5,        0},
    '{5, 6, 14,  4194304},
    '{3, 5,  4, -4194304},
    '{1, 6, 15,  8388607},
    '{5, 1,  0, -8388608}
  };

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic feed(input int nbits, input int pat, input int expv);
    fv = -1; nv = 0; nbad = 0;
    for (int b = 0; b < nbits; b++) begin
      @(negedge clk); bit_en = 1'b1; pdm_bit = pat[b % 4];
      @(negedge clk); bit_en = 1'b0;
      if (pcm_valid) begin
        nv++;
        if (fv < 0) fv = b;
        if ($signed(pcm_out) != expv) begin
          nbad++;
          $display("FAIL R5 sample actual=%0d expected=%0d", $signed(pcm_out), expv);
        end
      end
      @(negedge clk);
      if (pcm_valid) wbad_tot++;
    end
  endtask

  task automatic set_mode(input int ord, input int code, input bit toggle);
    @(negedge clk);
    if (toggle) begin run_en = 1'b0; @(negedge clk); end
    mode = {4'(code), 4'(ord)};
    run_en = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(pcm_valid == 1'b0, "R1 valid at reset", pcm_valid, 0);
    chk(pcm_out == 24'd0, "R1 sample at reset", pcm_out, 0);
    rst_n = 1'b1;
    // R1 + R3: order field 0 ignored, order stays 3
    set_mode(0, 1, 0);
    feed(40, 15, 8388607);
    chk(fv == 31, "R1 R3 default order first sample bit", fv, 31);

    for (int v = 0; v < 9; v++) begin
      int n, r;
      n = VEC[v][0]; r = 8 << (VEC[v][1] - 1);
      set_mode(n, VEC[v][1], 1);
      feed((n + 3) * r, VEC[v][2], VEC[v][3]);
      chk(nbad == 0, "R4 R5 sample values", nbad, 0);
      chk(nv == 3, "R6 samples per R bits", nv, 3);
      chk(fv == (n + 1) * r - 1, "R7 settling boundary", fv, (n + 1) * r - 1);
    end

    // R3: invalid order mid-run does not restart
    set_mode(2, 1, 1);
    feed(24, 15, 8388607);
    chk(fv == 23, "R3 order 2 first sample", fv, 23);
    set_mode(7, 1, 0);
    feed(8, 15, 8388607);
    chk(nv == 1 && fv == 7, "R3 invalid order ignored", fv, 7);

    // R7: ratio change without enable drop restarts
    set_mode(2, 2, 0);
    feed(48, 15, 8388607);
    chk(fv == 47 && nv == 1, "R7 restart on ratio change", fv, 47);
    // R7: enable drop restarts
    set_mode(2, 2, 1);
    feed(48, 15, 8388607);
    chk(fv == 47 && nv == 1, "R7 restart on enable drop", fv, 47);

    // R2: disable codes
    held = pcm_out;
    set_mode(2, 0, 0);
    feed(64, 15, 0);
    chk(nv == 0, "R2 code 0 no samples", nv, 0);
    chk(pcm_out == held, "R2 code 0 sample held", pcm_out, held);
    set_mode(2, 9, 0);
    feed(64, 0, 0);
    chk(nv == 0, "R2 code 9 no samples", nv, 0);
    chk(pcm_out == held, "R2 code 9 sample held", pcm_out, held);

    chk(wbad_tot == 0, "R6 one-cycle pulse", wbad_tot, 0);
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule